// File: doc/BRIEF.md
# SPI Master Shift Engine

A single-channel SPI master driven through three word-wide registers: one control word and two data words. Software loads the data words, then writes the control word with the start bit set. The two data words shift left together as one 64-bit chain, MSB first. The top bit of the chain drives MOSI, and each sampled MISO bit enters at the bottom.

A frame of N bits therefore sends the top N bits of the upper word. It leaves the N received bits in the low end of the lower word. Everything else in the chain moves up by N places. The serial clock runs at the bus clock divided by 4×(R+1), where R is the rate field. One of four active-low chip selects frames the transfer, and software polls a busy bit in the control word.

Top module: `spi_shift_master`

## Requirements
- R1: After reset, every chip select is high, SCLK and MOSI are low, and the control word and both data words read as zero.
- R2: A control write with bit 0 set while the engine is idle starts a frame. From the next cycle, the control word reads with bit 31 (busy) at 1 and bit 0 at 0.
- R3: A frame of length N (control bits 22:16) with rate R (control bits 9:4) holds busy high for exactly (2N+1)·2(R+1) bus cycles.
- R4: When no frame is running, SCLK rests at the polarity bit (control bit 1). Each frame produces exactly N SCLK pulses away from that level.
- R5: During a frame, only the chip select numbered by control bits 24:23 is low. All chip selects are high while idle.
- R6: The chain shifts left N places per frame, MSB first. MOSI carries the top bit of the upper data word (address 1), so the upper word ends as its old contents shifted left by N, filled from below by the next lower-word bits.
- R7: Each bit sampled on MISO at a leading SCLK edge enters the bottom of the lower data word (address 2). After the frame, the low N bits of the lower word hold the received bits, first-received most significant.
- R8: Writes to any register while busy is 1 have no effect on configuration or data.
- R9: The first SCLK edge comes one half SCLK period (2(R+1) cycles) after the chip select falls. The chip select rises one half period after the last SCLK edge.
- R10: The control word reads back the polarity, mode, read-flag, rate, length and select fields that were written, at the positions given above (bit 2 mode, bit 3 read flag).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 control, 1 upper data, 2 lower data |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the selected register |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |

## Verification
The bench builds the block with its default parameters: four selects, a 6-bit rate field and a 7-bit length field. It sweeps every frame length from 4 to 32 and adds lengths 1, 40 and 64. It crosses these with three rates, both polarities and all four selects.

MISO is looped back from MOSI, either straight or inverted. The expected chain contents are then a 64-bit rotation, or a shift with inverted fill, computed arithmetically. Some frames also receive register writes while busy, so the ignore rule is checked against the timing, the data and the readback.

// File: rtl/spi_shift_master.sv
module spi_shift_master #(
  parameter int NCS = 4,
  parameter int RW  = 6,
  parameter int LW  = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic [NCS-1:0] cs_n
);
  localparam int CSW = $clog2(NCS);
  localparam int HW  = RW + 1;
  localparam int CW  = LW + 1;
  localparam int RATE_LSB = 4;
  localparam int LEN_LSB  = 16;
  localparam int SEL_LSB  = 23;

  logic [63:0]    chain;
  logic           busy, act, cpol, alt, rdf, mq;
  logic [RW-1:0]  rate;
  logic [LW-1:0]  len;
  logic [CSW-1:0] csel;
  logic [HW-1:0]  hcnt;
  logic [CW-1:0]  ecnt;

  wire idle_wr = wr_en && !busy;
  wire [HW-1:0] hlast = {rate, 1'b1};
  wire [CW-1:0] elast = {len, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0; busy <= 1'b0; act <= 1'b0; cpol <= 1'b0; alt <= 1'b0;
      rdf <= 1'b0; mq <= 1'b0; rate <= '0; len <= '0; csel <= '0;
      hcnt <= '0; ecnt <= '0;
    end else begin
      if (idle_wr && addr == 2'd0) begin
        cpol <= wdata[1];
        alt  <= wdata[2];
        rdf  <= wdata[3];
        rate <= wdata[RATE_LSB +: RW];
        len  <= wdata[LEN_LSB +: LW];
        csel <= wdata[SEL_LSB +: CSW];
        if (wdata[0]) begin
          busy <= 1'b1;
          act  <= 1'b0;
          ecnt <= '0;
          hcnt <= {wdata[RATE_LSB +: RW], 1'b1};
        end
      end
      if (idle_wr && addr == 2'd1) chain[63:32] <= wdata;
      if (idle_wr && addr == 2'd2) chain[31:0]  <= wdata;
      if (busy) begin
        if (hcnt != '0) hcnt <= hcnt - 1'b1;
        else begin
          hcnt <= hlast;
          if (ecnt == elast) busy <= 1'b0;
          else begin
            act  <= ~act;
            ecnt <= ecnt + 1'b1;
            if (!act) mq <= miso;
            else chain <= {chain[62:0], mq};
          end
        end
      end
    end
  end

  assign sclk = act ^ cpol;
  assign mosi = chain[63];

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_n[i] = !(busy && csel == CSW'(i));
  end

  logic [31:0] ctrl;
  always_comb begin
    ctrl = '0;
    ctrl[31] = busy;
    ctrl[1]  = cpol;
    ctrl[2]  = alt;
    ctrl[3]  = rdf;
    ctrl[RATE_LSB +: RW] = rate;
    ctrl[LEN_LSB +: LW]  = len;
    ctrl[SEL_LSB +: CSW] = csel;
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = ctrl;
      2'd1:    rdata = chain[63:32];
      2'd2:    rdata = chain[31:0];
      default: rdata = '0;
    endcase
  end
endmodule

module spi_shift_master_chk #(
  parameter int NCS = 4,
  parameter int RW  = 6,
  parameter int LW  = 7,
  parameter int CSW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [1:0]     addr,
  input logic [31:0]    wdata,
  input logic           busy,
  input logic           cpol,
  input logic           sclk,
  input logic [NCS-1:0] cs_n,
  input logic [RW-1:0]  rate,
  input logic [LW-1:0]  len,
  input logic [CSW-1:0] csel
);
  p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && wdata[0] && !busy) |=> busy);

  p_idle_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk == cpol);

  p_one_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) == (busy ? 1 : 0));

  p_hold_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && addr == 2'd0) |=>
      ($stable(rate) && $stable(len) && $stable(csel) && $stable(cpol)));

  p_quiet_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $stable(sclk));
endmodule

bind spi_shift_master spi_shift_master_chk #(.NCS(NCS), .RW(RW), .LW(LW), .CSW(CSW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .busy(busy), .cpol(cpol), .sclk(sclk), .cs_n(cs_n),
  .rate(rate), .len(len), .csel(csel)
);

// File: tb/spi_shift_master_bench.sv
module spi_shift_master_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, inv = 1'b0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic sclk, mosi, miso;
  logic [3:0] cs_n;
  int tests = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign miso = mosi ^ inv;

  spi_shift_master u_spi_shift_master (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic frame(input int n, input int r, input bit pol, input int cs,
                       input logic [31:0] hi, input logic [31:0] lo,
                       input bit iv, input bit midwr);
    logic [31:0] cw, v;
    logic [63:0] full, expv, mask;
    int h, k, low, pulses, first, last;
    bit prev, csok;
    h = 2 * (r + 1);
    inv = iv;
    wr(2'd1, hi);
    wr(2'd2, lo);
    cw = {7'd0, 2'(cs), 7'(n), 6'd0, 6'(r), 1'b1, 1'b0, pol, 1'b1};
    wr(2'd0, cw);
    rd(2'd0, v);
    chk(v[31] == 1'b1 && v[0] == 1'b0, "R2 busy/start readback", {32'd0, v}, 64'h80000000);
    chk(sclk == pol, "R4 idle level", {63'd0, sclk}, {63'd0, pol});
    k = 1; low = 0; pulses = 0; first = 0; last = 0; prev = pol; csok = 1'b1;
    while (cs_n != 4'hF && k < 20000) begin
      if (cs_n != ~(4'b1 << cs)) csok = 1'b0;
      if (sclk != prev) begin
        if (first == 0) first = k;
        last = k;
        if (sclk != pol) pulses++;
        prev = sclk;
      end
      low++;
      if (midwr && k == 3) begin wr_en = 1'b1; addr = 2'd0; wdata = 32'h01FF_FFF7 ^ cw; end
      if (midwr && k == 4) begin addr = 2'd1; wdata = ~hi; end
      if (midwr && k == 5) begin addr = 2'd2; wdata = ~lo; end
      if (midwr && k == 6) wr_en = 1'b0;
      @(negedge clk);
      k++;
    end
    chk(csok, "R5 select pattern", 64'(cs_n), 64'(~(4'b1 << cs)));
    chk(low == (2*n+1)*h, "R3 frame length", 64'(low), 64'((2*n+1)*h));
    chk(pulses == n, "R4 pulse count", 64'(pulses), 64'(n));
    chk(first == h + 1 && last == 2*n*h + 1, "R9 select to edge spacing",
        {32'(first), 32'(last)}, {32'(h+1), 32'(2*n*h+1)});
    full = {hi, lo};
    mask = (n == 64) ? '1 : ((64'd1 << n) - 1);
    if (iv) expv = (full << n) | (~(full >> (64 - n)) & mask);
    else    expv = (full << n) | ((full >> (64 - n)) & mask);
    rd(2'd1, v);
    chk(v == expv[63:32], "R6 upper word after shift", {32'd0, v}, {32'd0, expv[63:32]});
    rd(2'd2, v);
    chk(v == expv[31:0], "R7 lower word received", {32'd0, v}, {32'd0, expv[31:0]});
    rd(2'd0, v);
    chk(v == (cw & ~32'h1), midwr ? "R8 write during frame ignored" : "R10 field readback",
        {32'd0, v}, {32'd0, cw & ~32'h1});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cs_n == 4'hF && sclk == 1'b0 && mosi == 1'b0, "R1 pins after reset",
        {58'd0, cs_n, sclk, mosi}, 64'h3C);
    rd(2'd0, v); chk(v == 0, "R1 control reset", 64'(v), 0);
    rd(2'd1, v); chk(v == 0, "R1 upper reset", 64'(v), 0);
    rd(2'd2, v); chk(v == 0, "R1 lower reset", 64'(v), 0);
    for (int n = 4; n <= 32; n++)
      frame(n, n % 3, n[0], n % 4, 32'hA5C3_0F96 ^ (32'(n) * 32'h01010101),
            32'h1234_5678 + 32'(n), n[1], 1'b0);
    frame(1, 0, 1'b0, 2, 32'h8000_0001, 32'hFFFF_FFFF, 1'b0, 1'b0);
    frame(40, 1, 1'b1, 3, 32'hDEAD_BEEF, 32'hC0FF_EE00, 1'b1, 1'b0);
    frame(64, 0, 1'b0, 1, 32'h0F0F_3C3C, 32'h9999_6666, 1'b0, 1'b0);
    frame(8, 2, 1'b0, 0, 32'hF000_0000, 32'h0000_0001, 1'b0, 1'b1);
    frame(16, 0, 1'b1, 3, 32'h5A5A_5A5A, 32'hFFFF_0000, 1'b1, 1'b1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule